// File: doc/BRIEF.md
# Dual-Path Output Combining Adder

This block sits at the output of a two-path filter. In combined mode it adds the two 32-bit partial results into one 32-bit result. In split mode it passes each path forward unchanged and does no addition. A configuration bit can shift the second path's result right by twelve positions before the sum. With that shift, two narrow filter halves together act as one wider filter, either wide data against narrow coefficients or narrow data against wide coefficients.

All outputs come from registers, so any input shows at the outputs after exactly one clock. The sum wraps modulo 2^32. A limiting stage further down the pipeline handles saturation.

Top module: `path_merge_adder`

## Requirements
- R1: While rst_n is low, out_main, out_aux and out_valid are all zero, and they are still zero on the first clock edge after rst_n goes high.
- R2: When split_mode=0 and prescale_en=0, out_main one cycle later equals (path_a + path_b) mod 2^32.
- R3: When split_mode=0 and prescale_en=1, out_main one cycle later equals (path_a + (path_b >>> 12)) mod 2^32. The shift is arithmetic: bit 31 of path_b fills the twelve top positions.
- R4: When split_mode=1, out_main one cycle later equals path_a and out_aux equals path_b. prescale_en has no effect in this mode.
- R5: When split_mode=0, out_aux is zero one cycle later.
- R6: out_valid one cycle later equals in_valid.
- R7: When in_valid=0, the data outputs hold their previous values.
- R8: A carry out of bit 31 is dropped with no other indication. For example, 0x7FFFFFFF + 1 gives 0x80000000 and 0xFFFFFFFF + 1 gives 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input sample qualifier |
| split_mode | input | 1 | 1 = two independent paths, 0 = combined sum |
| prescale_en | input | 1 | 1 = shift path_b right arithmetically by 12 before adding |
| path_a | input | 32 | First path partial result |
| path_b | input | 32 | Second path partial result |
| out_valid | output | 1 | Output qualifier |
| out_main | output | 32 | Combined sum, or path_a in split mode |
| out_aux | output | 32 | path_b in split mode, zero in combined mode |

## Verification
Assertions check on every cycle the one-cycle relationship from inputs to outputs. They cover the sum with and without the shift, the split-mode pass-through, the zeroed auxiliary output, holding while idle, and the valid pipeline. Only the bench scenarios can show that a given operand pattern produces a specific numeric result. Those scenarios include sign extension of negative second-path values, wraparound at both the signed and unsigned limits, and prescale_en having no effect in split mode.

// File: rtl/pma_pkg.sv
package pma_pkg;
    parameter int unsigned WORD_W  = 32;
    parameter int unsigned SHIFT_N = 12;

    typedef logic [WORD_W-1:0] word_t;

    typedef struct packed {
        logic  vld;
        word_t main;
        word_t aux;
    } out_state_t;
endpackage

// File: rtl/pma_prescale.sv
module pma_prescale #(
    parameter int unsigned W  = 32,
    parameter int unsigned SH = 12
) (
    input  logic         en,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    localparam int unsigned KEEP = W - SH;

    always_comb begin
        if (en) dout = {{SH{din[W-1]}}, din[W-1:SH]};
        else    dout = din;
    end

    always_comb begin
        if (en) assert_sign_fill_R3: assert (dout[W-1:KEEP] == {SH{din[W-1]}});
    end
endmodule

// File: rtl/pma_combine.sv
module pma_combine #(
    parameter int unsigned W = 32
) (
    input  logic         split,
    input  logic [W-1:0] a,
    input  logic [W-1:0] b_scaled,
    input  logic [W-1:0] b_raw,
    output logic [W-1:0] main_o,
    output logic [W-1:0] aux_o
);
    logic [W-1:0] sum;

    always_comb begin
        sum = a + b_scaled;
        if (split) begin
            main_o = a;
            aux_o  = b_raw;
        end else begin
            main_o = sum;
            aux_o  = '0;
        end
    end
endmodule

// File: rtl/path_merge_adder.sv
module path_merge_adder
    import pma_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        in_valid,
    input  logic        split_mode,
    input  logic        prescale_en,
    input  logic [31:0] path_a,
    input  logic [31:0] path_b,
    output logic        out_valid,
    output logic [31:0] out_main,
    output logic [31:0] out_aux
);
    word_t      b_scaled;
    word_t      comb_main;
    word_t      comb_aux;
    out_state_t st_d, st_q;

    pma_prescale #(.W(WORD_W), .SH(SHIFT_N)) u_scale (
        .en   (prescale_en & ~split_mode),
        .din  (path_b),
        .dout (b_scaled)
    );

    pma_combine #(.W(WORD_W)) u_comb (
        .split    (split_mode),
        .a        (path_a),
        .b_scaled (b_scaled),
        .b_raw    (path_b),
        .main_o   (comb_main),
        .aux_o    (comb_aux)
    );

    always_comb begin
        st_d     = st_q;
        st_d.vld = in_valid;
        if (in_valid) begin
            st_d.main = comb_main;
            st_d.aux  = comb_aux;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign out_valid = st_q.vld;
    assign out_main  = st_q.main;
    assign out_aux   = st_q.aux;

    assert_reset_clear_R1: assert property (@(posedge clk)
        !$past(rst_n) |-> (out_main == '0 && out_aux == '0 && !out_valid));
    assert_plain_sum_R2: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && !split_mode && !prescale_en |=> out_main == $past(path_a) + $past(path_b));
    assert_scaled_sum_R3: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && !split_mode && prescale_en |=>
        out_main == $past(path_a) + word_t'($signed($past(path_b)) >>> SHIFT_N));
    assert_split_pass_R4: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && split_mode |=> out_main == $past(path_a) && out_aux == $past(path_b));
    assert_aux_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && !split_mode |=> out_aux == '0);
    assert_valid_pipe_R6: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> out_valid == $past(in_valid));
    assert_idle_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(out_main) && $stable(out_aux));
endmodule

// File: tb/path_merge_adder_test.sv
module path_merge_adder_test;
    logic        clk = 0;
    logic        rst_n = 0;
    logic        in_valid = 0, split_mode = 0, prescale_en = 0;
    logic [31:0] path_a = 0, path_b = 0;
    logic        out_valid;
    logic [31:0] out_main, out_aux;
    int total = 0, bad = 0;

    always #4 clk = ~clk;

    path_merge_adder uut (.*);

    // {split, prescale, a, b, exp_main, exp_aux}
    typedef struct packed {
        logic sp; logic ps;
        logic [31:0] a; logic [31:0] b; logic [31:0] em; logic [31:0] ex;
    } vec_t;
    localparam int NV = 9;
    localparam vec_t VECS [NV] = '{
        '{1'b0,1'b0,32'd100,32'd23,32'd123,32'd0},                     // R2
        '{1'b0,1'b0,32'hFFFF_FFF6,32'd4,32'hFFFF_FFFA,32'd0},          // R2 negative
        '{1'b0,1'b1,32'd5,32'h0000_3000,32'd8,32'd0},                   // R3
        '{1'b0,1'b1,32'd0,32'h8000_0000,32'hFFF8_0000,32'd0},          // R3 sign fill
        '{1'b0,1'b1,32'd10,32'hFFFF_F000,32'd9,32'd0},                 // R3 -1
        '{1'b1,1'b0,32'h1234_5678,32'hCAFE_F00D,32'h1234_5678,32'hCAFE_F00D}, // R4
        '{1'b1,1'b1,32'hA5A5_0000,32'h0000_F000,32'hA5A5_0000,32'h0000_F000}, // R4 prescale ignored
        '{1'b0,1'b0,32'h7FFF_FFFF,32'd1,32'h8000_0000,32'd0},          // R8
        '{1'b0,1'b0,32'hFFFF_FFFF,32'd1,32'd0,32'd0}                   // R8
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic drive(input logic v, input logic sp, input logic ps,
                         input logic [31:0] a, input logic [31:0] b);
        in_valid = v; split_mode = sp; prescale_en = ps; path_a = a; path_b = b;
        @(posedge clk); #2;
    endtask

    initial begin
        #200000;
        bad++; total++;
        $display("FAIL watchdog actual=hang expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        in_valid = 1; path_a = 32'h1111; path_b = 32'h2222;
        repeat (2) @(posedge clk);
        #2;
        chk("R1 main", out_main, 0);
        chk("R1 aux", out_aux, 0);
        chk("R1 valid", {31'd0, out_valid}, 0);
        in_valid = 0;
        @(negedge clk); rst_n = 1;
        @(posedge clk); #2;
        chk("R1 after release", out_main, 0);

        for (int i = 0; i < NV; i++) begin
            drive(1'b1, VECS[i].sp, VECS[i].ps, VECS[i].a, VECS[i].b);
            chk($sformatf("R2/R3/R4/R8 vec%0d main", i), out_main, VECS[i].em);
            chk($sformatf("R4/R5 vec%0d aux", i), out_aux, VECS[i].ex);
            chk("R6 valid", {31'd0, out_valid}, 1);
        end

        // R5: aux cleared after split data
        drive(1'b1, 1'b1, 1'b0, 32'd1, 32'd2);
        drive(1'b1, 1'b0, 1'b0, 32'd1, 32'd2);
        chk("R5 aux zero", out_aux, 0);
        chk("R2 sum", out_main, 3);

        // R7: hold while idle
        drive(1'b0, 1'b1, 1'b1, 32'hDEAD, 32'hBEEF);
        chk("R7 main hold", out_main, 3);
        chk("R7 aux hold", out_aux, 0);
        chk("R6 valid low", {31'd0, out_valid}, 0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule